// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block sits between a producer that writes a trace stream to a linear input address window and the memory system, where the buffer is spread over scattered 4 KB physical pages. Each incoming address is either forwarded unchanged (pass-through mode) or translated (translate mode). Translation uses flat page tables held in memory. Each table maps 1 MB of input space through up to 256 page pointers, and the tables are chained in both directions by two link entries near the end of each table.

The block remembers one current table, as its physical address and its 1 MB window number. A request in that window costs a single table fetch. A request in a later or earlier window makes the block step along next or previous links, one fetch per step, before it fetches the data entry. Any entry whose valid bit is clear ends the lookup with a fault. A failed lookup leaves the current table where it was. Software programs the block through a small register write port while the block is disabled. Requests enter on a valid/ready channel and results leave on a valid/ready channel. The upstream side sees back-pressure whenever a request is in flight, and the result is held until the consumer takes it. Table fetches go out on a valid/ready read port, and the reply returns one 64-bit word per request.

Top module: `pgchain_xlat`

## Requirements
- R1: After reset the block is disabled with ready high, and in_ready, out_valid, mem_rd_valid and cfg_err are all low.
- R2: With the mode register bit 0 at 0 (pass-through), each accepted address comes out unchanged with out_fault low and no table fetch.
- R3: In translate mode, a request in the current window fetches one entry at table address + 8 × entry index, where the entry index is bits [19:12] of (address − input base). The output is entry bits [AW-1:12] joined with address bits [11:0]. Entry bit 0 is the valid flag and entry bits [11:1] are ignored.
- R4: A data entry with bit 0 clear gives out_fault high with out_addr zero.
- R5: If the window number (address − input base) >> 20 is above the current one, the block fetches the next link at byte offset 0xFF8 (entry 511) of the table. If it is below, the block fetches the previous link at offset 0xFF0 (entry 510). Each step is one fetch, so a lookup costs |target − current| + 1 fetches.
- R6: A link with bit 0 clear ends the walk with a fault, and the current table stays unchanged for the next request.
- R7: An address below the input base faults without any fetch.
- R8: A successful translation makes its table the current one. Enabling the block resets the current table to the table base at window 0.
- R9: Register select 0 is control (bit 0 enable), 1 is mode (bit 0: 1 translate), 2 is the table base (bits [11:0] dropped) and 3 is the input base (bits [19:0] dropped). A write is accepted only while the block is disabled with no walk in flight, except that a control write clearing enable is always accepted. A rejected write changes nothing and pulses cfg_err in the next cycle.
- R10: st_ready is low while a walk is in flight. A walk still in flight when the block is disabled completes, and st_ready then returns high. in_ready is low while the block is disabled.
- R11: out_valid with out_addr and out_fault, and mem_rd_valid with mem_rd_addr, hold steady until their handshakes complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| cfg_err | output | 1 | Pulse: the previous write was rejected |
| st_enabled | output | 1 | Enable state |
| st_ready | output | 1 | No table walk in flight |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted |
| in_addr | input | AW | Input-window address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_addr | output | AW | Translated address |
| out_fault | output | 1 | Lookup failed |
| mem_rd_valid | output | 1 | Table fetch request |
| mem_rd_ready | input | 1 | Fetch request accepted |
| mem_rd_addr | output | AW | Entry byte address |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | 64 | Fetched table entry |

## Verification
A wrong current-table register does not show up as a wrong address right away. It shows up at once as a wrong number of fetches, or a wrong first fetch address, on the next translate request. The bench therefore counts and logs every fetch per lookup over a sweep of windows and entries, visited in a scrambled order. A missed commit, or a commit made on a fault, shows up one request later as a fetch count that does not fit the distance between windows. Faults, masking and configuration rejection are each checked at the ports on the very request that follows the stimulus.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int PAGE_SH  = 12;
  localparam int WIN_SH   = 20;
  localparam int ENT_SH   = 3;
  localparam int IDX_PREV = 510;
  localparam int IDX_NEXT = 511;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_TBASE = 2'd2,
    SEL_IBASE = 2'd3
  } cfg_sel_e;

  typedef enum logic [2:0] {
    W_IDLE, W_LOOK, W_FETCH, W_WAIT, W_OUT
  } walk_st_e;

  typedef enum logic [1:0] {
    F_DATA, F_NEXT, F_PREV
  } fetch_kind_e;
endpackage

// File: rtl/pgx_cfg.sv
module pgx_cfg import pgx_pkg::*; #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  input  logic          walk_idle,
  output logic          en,
  output logic          xlat_mode,
  output logic [AW-1:0] tbase,
  output logic [AW-1:0] ibase,
  output logic          load_cur,
  output logic          err
);
  logic is_ctrl, stop_req, open_ok, accept;
  logic unused_wbits;

  assign unused_wbits = ^wdata[PAGE_SH-1:1];

  always_comb begin
    is_ctrl  = (sel == SEL_CTRL);
    stop_req = is_ctrl && !wdata[0];
    open_ok  = !en && walk_idle;
    accept   = wr && (stop_req || open_ok);
    load_cur = accept && is_ctrl && wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      xlat_mode <= 1'b0;
      tbase     <= '0;
      ibase     <= '0;
      err       <= 1'b0;
    end else begin
      err <= wr && !accept;
      if (accept) begin
        case (cfg_sel_e'(sel))
          SEL_CTRL:  en        <= wdata[0];
          SEL_MODE:  xlat_mode <= wdata[0];
          SEL_TBASE: tbase     <= {wdata[AW-1:PAGE_SH], {PAGE_SH{1'b0}}};
          SEL_IBASE: ibase     <= {wdata[AW-1:WIN_SH], {WIN_SH{1'b0}}};
          default:   en        <= en;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgx_index.sv
module pgx_index import pgx_pkg::*; #(
  parameter int AW = 40
) (
  input  logic [AW-1:0]             addr,
  input  logic [AW-1:0]             ibase,
  output logic                      below,
  output logic [AW-WIN_SH-1:0]      tidx,
  output logic [WIN_SH-PAGE_SH-1:0] eidx
);
  logic [AW-1:0] diff;
  logic          unused_low;

  assign diff       = addr - ibase;
  assign below      = addr < ibase;
  assign tidx       = diff[AW-1:WIN_SH];
  assign eidx       = diff[WIN_SH-1:PAGE_SH];
  assign unused_low = ^diff[PAGE_SH-1:0];
endmodule

// File: rtl/pgx_walk.sv
module pgx_walk import pgx_pkg::*; #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          xlat_mode,
  input  logic [AW-1:0] tbase,
  input  logic [AW-1:0] ibase,
  input  logic          load_cur,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_fault,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data,
  output logic          walk_idle
);
  localparam int TW = AW - WIN_SH;
  localparam int EW = WIN_SH - PAGE_SH;
  localparam logic [AW-1:0] OFF_PREV = AW'(IDX_PREV << ENT_SH);
  localparam logic [AW-1:0] OFF_NEXT = AW'(IDX_NEXT << ENT_SH);

  walk_st_e      st;
  fetch_kind_e   kind;
  logic [AW-1:0] req_addr, cur_tab, wk_tab, maddr, oaddr;
  logic [TW-1:0] cur_win, wk_win, tidx;
  logic [EW-1:0] eidx;
  logic          ofault, below;
  logic [AW-1:0] ent_page, data_off;
  logic          ent_ok;
  logic          unused_rsp;

  pgx_index #(.AW(AW)) u_index (
    .addr  (req_addr),
    .ibase (ibase),
    .below (below),
    .tidx  (tidx),
    .eidx  (eidx)
  );

  assign ent_page   = {mem_rsp_data[AW-1:PAGE_SH], {PAGE_SH{1'b0}}};
  assign ent_ok     = mem_rsp_data[0];
  assign unused_rsp = ^{mem_rsp_data[63:AW], mem_rsp_data[PAGE_SH-1:1]};
  assign data_off   = {{(AW-EW-ENT_SH){1'b0}}, eidx, {ENT_SH{1'b0}}};

  assign in_ready     = en && (st == W_IDLE);
  assign out_valid    = (st == W_OUT);
  assign out_addr     = oaddr;
  assign out_fault    = ofault;
  assign mem_rd_valid = (st == W_FETCH);
  assign mem_rd_addr  = maddr;
  assign walk_idle    = (st == W_IDLE) || (st == W_OUT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      kind     <= F_DATA;
      req_addr <= '0;
      cur_tab  <= '0;
      cur_win  <= '0;
      wk_tab   <= '0;
      wk_win   <= '0;
      maddr    <= '0;
      oaddr    <= '0;
      ofault   <= 1'b0;
    end else begin
      if (load_cur) begin
        cur_tab <= tbase;
        cur_win <= '0;
      end
      case (st)
        W_IDLE: begin
          if (in_valid && in_ready) begin
            req_addr <= in_addr;
            if (xlat_mode) begin
              wk_tab <= cur_tab;
              wk_win <= cur_win;
              st     <= W_LOOK;
            end else begin
              oaddr  <= in_addr;
              ofault <= 1'b0;
              st     <= W_OUT;
            end
          end
        end
        W_LOOK: begin
          if (below) begin
            oaddr  <= '0;
            ofault <= 1'b1;
            st     <= W_OUT;
          end else begin
            if (tidx == wk_win) begin
              maddr <= wk_tab + data_off;
              kind  <= F_DATA;
            end else if (tidx > wk_win) begin
              maddr <= wk_tab + OFF_NEXT;
              kind  <= F_NEXT;
            end else begin
              maddr <= wk_tab + OFF_PREV;
              kind  <= F_PREV;
            end
            st <= W_FETCH;
          end
        end
        W_FETCH: begin
          if (mem_rd_ready) st <= W_WAIT;
        end
        W_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_ok) begin
              oaddr  <= '0;
              ofault <= 1'b1;
              st     <= W_OUT;
            end else begin
              case (kind)
                F_DATA: begin
                  oaddr   <= {mem_rsp_data[AW-1:PAGE_SH], req_addr[PAGE_SH-1:0]};
                  ofault  <= 1'b0;
                  cur_tab <= wk_tab;
                  cur_win <= wk_win;
                  st      <= W_OUT;
                end
                F_NEXT: begin
                  wk_tab <= ent_page;
                  wk_win <= wk_win + TW'(1);
                  st     <= W_LOOK;
                end
                F_PREV: begin
                  wk_tab <= ent_page;
                  wk_win <= wk_win - TW'(1);
                  st     <= W_LOOK;
                end
                default: st <= W_IDLE;
              endcase
            end
          end
        end
        W_OUT: begin
          if (out_ready) st <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgchain_xlat.sv
module pgchain_xlat import pgx_pkg::*; #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          cfg_err,
  output logic          st_enabled,
  output logic          st_ready,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_fault,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data
);
  logic          en, xlat_mode, load_cur, walk_idle;
  logic [AW-1:0] tbase, ibase;

  pgx_cfg #(.AW(AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_wr),
    .sel       (cfg_sel),
    .wdata     (cfg_wdata),
    .walk_idle (walk_idle),
    .en        (en),
    .xlat_mode (xlat_mode),
    .tbase     (tbase),
    .ibase     (ibase),
    .load_cur  (load_cur),
    .err       (cfg_err)
  );

  pgx_walk #(.AW(AW)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .xlat_mode     (xlat_mode),
    .tbase         (tbase),
    .ibase         (ibase),
    .load_cur      (load_cur),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_addr       (in_addr),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_fault     (out_fault),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .walk_idle     (walk_idle)
  );

  assign st_enabled = en;
  assign st_ready   = walk_idle;
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          cfg_err,
  input logic          st_enabled,
  input logic          st_ready,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] in_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_fault,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr
);
  logic [AW-1:0] acc_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_addr <= '0;
    else if (in_valid && in_ready) acc_addr <= in_addr;
  end

  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_fault));

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !st_ready);

  p_no_accept_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> st_enabled);

  p_reenable_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && (cfg_sel == 2'd0) && cfg_wdata[0] && st_enabled |=> cfg_err);

  p_offset_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fault |-> out_addr[11:0] == acc_addr[11:0]);

  p_entry_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> mem_rd_addr[2:0] == 3'b000);
endmodule

bind pgchain_xlat pgx_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_pgchain_xlat.sv
`timescale 1ns/1ps
module tb_pgchain_xlat;
  localparam int AW = 32;
  localparam logic [31:0] IB = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic cfg_err, st_enabled, st_ready;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [AW-1:0] in_addr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [AW-1:0] out_addr;
  logic out_fault;
  logic mem_rd_valid, mem_rd_ready;
  logic [AW-1:0] mem_rd_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int fire_total = 0;
  logic [31:0] fire_log [16];
  logic stall_tog = 1'b0;
  logic mem_stall = 1'b0;
  int bp = 0;
  int curw = 0;

  always #4 clk = ~clk;

  pgchain_xlat #(.AW(AW)) dut (.*);

  function automatic logic [31:0] tb_addr(int k);
    return 32'h0010_0000 + 32'(k) * 32'h3000;
  endfunction

  function automatic logic [31:0] phys(int p);
    return 32'h8000_0000 + ((32'(p) ^ 32'h2A5) << 12);
  endfunction

  function automatic logic [63:0] model(logic [31:0] a);
    logic [63:0] r;
    logic [31:0] t;
    int idx;
    r = '0;
    idx = int'(a[11:3]);
    for (int k = 0; k < 4; k++) begin
      t = tb_addr(k);
      if (a[31:12] == t[31:12]) begin
        if (idx < 256) begin
          if (!(k == 3 && idx >= 200))
            r = {32'h0, phys(k*256+idx)} | 64'(((k*256+idx) & 1023) << 1) | 64'h1;
        end else if (idx == 510 && k > 0) begin
          r = {32'h0, tb_addr(k-1)} | 64'h11;
        end else if (idx == 511 && k < 3) begin
          r = {32'h0, tb_addr(k+1)} | 64'h801;
        end
      end
    end
    return r;
  endfunction

  assign mem_rd_ready = mem_stall ? stall_tog : 1'b1;

  always @(posedge clk) begin
    stall_tog <= ~stall_tog;
    mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
    mem_rsp_data <= model(mem_rd_addr);
    if (mem_rd_valid && mem_rd_ready) begin
      fire_log[fire_total % 16] <= mem_rd_addr;
      fire_total <= fire_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d, output logic err);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    err = cfg_err;
  endtask

  task automatic do_xlat(input logic [31:0] a, output logic [31:0] oa, output logic of,
                         output int nf, output int n0);
    @(negedge clk);
    out_ready = (bp == 0);
    in_valid = 1'b1; in_addr = a; n0 = fire_total;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    oa = out_addr; of = out_fault; nf = fire_total - n0;
    for (int h = 0; h < bp; h++) begin
      @(negedge clk);
      chk(out_valid && out_addr == oa && out_fault == of, "R11 hold", {31'd0, out_fault, out_addr}, {31'd0, of, oa});
    end
    out_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_pt(input logic [31:0] a);
    logic [31:0] oa; logic of; int nf, n0;
    do_xlat(a, oa, of, nf, n0);
    chk(oa == a && !of, "R2 pass addr", {31'd0, of, oa}, {32'd0, a});
    chk(nf == 0, "R2 no fetch", nf, 0);
  endtask

  task automatic run_one(input logic [31:0] a);
    logic [31:0] oa, ea, ef; logic of, xf; int nf, n0, xn, t, e, steps;
    string ftag;
    xf = 1'b0; ea = '0; xn = 0; t = 0; e = 0; steps = 0; ftag = "R3";
    if (a < IB) begin
      xf = 1'b1; xn = 0; ftag = "R7";
    end else begin
      t = int'((a - IB) >> 20);
      e = int'(((a - IB) >> 12) & 32'hFF);
      steps = (t > curw) ? t - curw : curw - t;
      if (t > 3) begin
        xf = 1'b1; xn = (3 - curw) + 1; ftag = "R6";
      end else if (t == 3 && e >= 200) begin
        xf = 1'b1; xn = steps + 1; ftag = "R4";
      end else begin
        ea = phys(t*256+e) | {20'd0, a[11:0]}; xn = steps + 1;
      end
    end
    do_xlat(a, oa, of, nf, n0);
    chk(of == xf, ftag, of, xf);
    chk(oa == ea, xf ? "R4 fault addr" : "R3 addr", oa, ea);
    chk(nf == xn, "R5 fetch count", nf, xn);
    if (!xf && nf >= 1) begin
      ef = tb_addr(t) + 32'(e) * 8;
      chk(fire_log[(n0 + nf - 1) % 16] == ef, "R3 entry fetch", fire_log[(n0 + nf - 1) % 16], ef);
      if (steps > 0) begin
        ef = tb_addr(curw) + ((t > curw) ? 32'hFF8 : 32'hFF0);
        chk(fire_log[n0 % 16] == ef, "R5 link fetch", fire_log[n0 % 16], ef);
      end
      curw = t;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic err;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!st_enabled && st_ready && !in_ready && !out_valid && !mem_rd_valid && !cfg_err,
        "R1 reset", {st_enabled, st_ready, in_ready, out_valid, mem_rd_valid, cfg_err}, 6'b010000);

    cfg_write(2'd2, tb_addr(0) | 32'hABC, err);
    chk(!err, "R9 tbase write", err, 0);
    cfg_write(2'd3, IB | 32'h000A_BCDE, err);
    chk(!err, "R9 ibase write", err, 0);
    cfg_write(2'd1, 32'd0, err);
    cfg_write(2'd0, 32'd1, err);
    chk(st_enabled && !err, "R9 enable", st_enabled, 1);
    for (int i = 0; i < 6; i++) run_pt(32'h1234_5678 + 32'(i) * 32'h0731_0F1D);
    cfg_write(2'd0, 32'd1, err);
    chk(err, "R9 reenable rejected", err, 1);
    cfg_write(2'd1, 32'd1, err);
    chk(err, "R9 mode write rejected", err, 1);
    run_pt(IB + 32'h0012_3456);

    cfg_write(2'd0, 32'd0, err);
    chk(!err && !st_enabled, "R10 disable", st_enabled, 0);
    chk(!in_ready, "R10 in_ready off", in_ready, 0);
    cfg_write(2'd1, 32'd1, err);
    cfg_write(2'd0, 32'd1, err);
    curw = 0;

    for (int i = 0; i < 48; i++)
      run_one(IB + (32'((i * 7) % 5) << 20) + (32'((i * 37) % 256) << 12) + 32'((i * 97) % 4096));
    run_one(IB + (32'd3 << 20) + (32'd199 << 12) + 32'h7);
    run_one(IB + (32'd3 << 20) + (32'd200 << 12));
    run_one(IB + (32'd3 << 20) + (32'd255 << 12) + 32'hFFF);
    run_one(IB + 32'hFFF);
    run_one(IB - 32'd1);
    run_one(32'h0000_1000);
    // R6: from window 1, a lookup past the chain end faults; the next one still starts at window 1
    run_one(IB + (32'd1 << 20) + (32'd9 << 12));
    run_one(IB + (32'd6 << 20));
    run_one(IB + (32'd1 << 20) + (32'd10 << 12) + 32'h3);
    // R8: repeated window needs a single fetch
    run_one(IB + (32'd1 << 20) + (32'd11 << 12));

    bp = 3; mem_stall = 1'b1;
    run_one(IB + (32'd3 << 20) + (32'd5 << 12) + 32'h21);
    run_one(IB + (32'd0 << 20) + (32'd77 << 12) + 32'h9);
    bp = 0; mem_stall = 1'b0;

    cfg_write(2'd2, 32'h0F00_0000, err);
    chk(err, "R9 tbase rejected", err, 1);

    fork
      run_one(IB + (32'd3 << 20) + (32'd5 << 12) + 32'h44);
      begin
        logic e2;
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 32'd0, e2);
        chk(!e2 && !st_enabled, "R10 disable mid-walk", {e2, st_enabled}, 0);
        while (!out_valid) begin
          if (mem_rd_valid) chk(!st_ready, "R10 busy", st_ready, 0);
          @(negedge clk);
        end
      end
    join
    chk(st_ready && !in_ready, "R10 drained", {st_ready, in_ready}, 2'b10);

    cfg_write(2'd0, 32'd1, err);
    chk(!err, "R8 enable again", err, 0);
    curw = 0;
    run_one(IB + (32'd2 << 20) + (32'd33 << 12) + 32'h5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule